// File: doc/BRIEF.md
# L2 Tag RAM Controller

This block sits between a cache controller and an external asynchronous tag RAM with its companion dirty-bit RAM, serving a direct-mapped second-level cache. One request is handled at a time, and each request is one of three operations:

- a lookup, which returns hit and dirty status;
- an update, which writes a new tag, the valid bit and a dirty value in a single write pulse;
- a cast-out read, which releases the shared tag-data lines, lets the RAM drive the stored tag, and rebuilds the victim line address.

The bus address is split into a RAM index and a stored tag. The split depends on the configured cache size. The top tag bits can be masked off to shrink the cacheable space. The hit and dirty inputs each have a programmable active level.

The bidirectional tag-data bus and the valid line are presented as separate out, in and drive-enable signals, which the pad ring combines into tri-state pins. Line addresses are 32 bits with A0 as bit 31 and 32-byte lines.

Top module: `l2tag_ctrl`

## Requirements
- R1: The size code selects the address split. Code 0 (256 KB) sends bits 17:5 to `ram_idx` and bits 31:18 to `tag_dout`. Code 1 (512 KB) uses bits 18:5 and 31:19. Code 2 or 3 (1 MB) uses bits 19:5 and 31:20. Both fields are right-aligned, with unused upper bits zero.
- R2: With `cfg_mask_n` = n, the n most significant bits of the active tag field are driven as zero on `tag_dout`.
- R3: A lookup accepted at clock edge E0 samples `hit_in` and `dirty_in` at edge E1. `res_valid` is high for the one cycle after E1. `res_hit` is 1 exactly when `hit_in` equals `cfg_hit_pol`, and `res_dirty` is 1 exactly when `dirty_in` equals `cfg_dirty_pol`.
- R4: An update accepted at E0 asserts `tag_we` for exactly WE_CYC cycles starting after E0. During the pulse and for one further cycle, `ram_idx`, `tag_dout` and `dirty_out` hold steady and the bus is driven. `dirty_out` carries the request's dirty value, and the valid line is driven high.
- R5: During the cast-out read cycle, `tag_oe` is high, `addr_oe` is low, and neither `tag_drive` nor `tv_drive` is asserted.
- R6: At the end of the read cycle, the block captures `tag_din` with the masked bits forced to zero. It then presents `vic_addr` = {tag, index, 5'b0}, placed per the R1 split, with a one-cycle `vic_valid`. Hit and dirty inputs have no effect on it.
- R7: The cycle after a cast-out read is a turnaround cycle: `tag_oe`, `addr_oe` and `tag_drive` are all low. Driving resumes in the next cycle.
- R8: `tv_drive` is low whenever `cfg_l2_en` is 0 or `cfg_dual_cpu` is 1. Otherwise it follows `tag_drive`, with `tv_out` = 1.
- R9: Requests while `busy` is high are ignored. Operation code 3 is ignored. The codes are 0 lookup, 1 update, 2 cast-out.
- R10: After reset, `tag_we`, `tag_oe`, `busy`, `res_valid` and `vic_valid` are low, and `addr_oe` and `tag_drive` are high.
- R11: `tag_we` and `tag_oe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Cache size code |
| cfg_mask_n | input | 4 | Number of top tag bits masked off |
| cfg_hit_pol | input | 1 | Active level of hit_in |
| cfg_dirty_pol | input | 1 | Active level of dirty_in |
| cfg_l2_en | input | 1 | L2 cache present and enabled |
| cfg_dual_cpu | input | 1 | Two-processor mode |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code |
| req_addr | input | 32 | Bus address |
| req_dirty | input | 1 | Dirty value for update |
| busy | output | 1 | Operation in progress |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | Lookup hit |
| res_dirty | output | 1 | Lookup line dirty |
| vic_valid | output | 1 | Victim address strobe |
| vic_addr | output | 32 | Reconstructed victim line address |
| ram_idx | output | 15 | Tag RAM index |
| tag_dout | output | 14 | Tag value toward the RAM |
| tag_din | input | 14 | Tag value from the RAM |
| tag_drive | output | 1 | Drive enable for the tag-data lines |
| tv_out | output | 1 | Valid line value |
| tv_drive | output | 1 | Drive enable for the valid line |
| dirty_out | output | 1 | Dirty RAM write data |
| tag_we | output | 1 | Tag and dirty RAM write enable |
| tag_oe | output | 1 | Tag RAM output enable |
| addr_oe | output | 1 | Address-latch output enable |
| hit_in | input | 1 | Hit from the tag RAM comparator |
| dirty_in | input | 1 | Dirty bit from the dirty RAM |

## Verification
The hardest case to reach is a cast-out, or a lookup, that returns a tag written earlier under a masked configuration. The result depends on the RAM having stored exactly what the block drove during an earlier write pulse. The bench keeps a RAM model that records only the block's pin values during `tag_we`, together with a separate shadow of the expected contents. Random operations are drawn over a small pool of addresses per size, mask and polarity phase, so that writes, hits, misses and victims on the same index recur often. Directed cases add a request during a busy cycle and the reserved operation code.

// File: rtl/l2tag_pkg.sv
package l2tag_pkg;
   typedef enum logic [1:0] {
      OP_LOOKUP  = 2'd0,
      OP_UPDATE  = 2'd1,
      OP_CASTOUT = 2'd2,
      OP_RSVD    = 2'd3
   } l2tag_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOOK,
      S_WRITE,
      S_HOLD,
      S_READ,
      S_TURN
   } l2tag_state_e;
endpackage

// File: rtl/l2tag_addr_map.sv
module l2tag_addr_map #(
   parameter int ADDR_W     = 32,
   parameter int LINE_W     = 5,
   parameter int BASE_IDX_W = 13,
   parameter int N_SIZES    = 3,
   parameter int SIZE_W     = 2,
   parameter int IDX_W      = 15,
   parameter int TAG_W      = 14,
   parameter int MASK_W     = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   input  logic [MASK_W-1:0] mask_n,
   output logic [SIZE_W-1:0] size_eff,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag,
   output logic [TAG_W-1:0]  keep
);
   logic [IDX_W-1:0] idx_c  [N_SIZES];
   logic [TAG_W-1:0] tag_c  [N_SIZES];
   logic [TAG_W-1:0] keep_c [N_SIZES];
   logic [TAG_W-1:0] tag_sel;

   assign size_eff = (int'(size) >= N_SIZES) ? SIZE_W'(N_SIZES - 1) : size;

   for (genvar s = 0; s < N_SIZES; s++) begin : g_size
      localparam int IW = BASE_IDX_W + s;
      localparam int TW = TAG_W - s;
      assign idx_c[s] = IDX_W'((addr >> LINE_W) & ((ADDR_W'(1) << IW) - ADDR_W'(1)));
      assign tag_c[s] = TAG_W'(addr >> (LINE_W + IW));
      for (genvar i = 0; i < TAG_W; i++) begin : g_keep
         assign keep_c[s][i] = (i + int'(mask_n)) < TW;
      end
   end

   always_comb begin
      idx     = '0;
      tag_sel = '0;
      keep    = '0;
      for (int s = 0; s < N_SIZES; s++) begin
         if (int'(size_eff) == s) begin
            idx     = idx_c[s];
            tag_sel = tag_c[s];
            keep    = keep_c[s];
         end
      end
   end

   assign tag = tag_sel & keep;
endmodule

// File: rtl/l2tag_victim.sv
module l2tag_victim #(
   parameter int ADDR_W     = 32,
   parameter int LINE_W     = 5,
   parameter int BASE_IDX_W = 13,
   parameter int N_SIZES    = 3,
   parameter int SIZE_W     = 2,
   parameter int IDX_W      = 15,
   parameter int TAG_W      = 14
) (
   input  logic [TAG_W-1:0]  tag_raw,
   input  logic [TAG_W-1:0]  keep,
   input  logic [IDX_W-1:0]  idx,
   input  logic [SIZE_W-1:0] size_eff,
   output logic [ADDR_W-1:0] line_addr
);
   logic [TAG_W-1:0]  tag_m;
   logic [ADDR_W-1:0] addr_c [N_SIZES];

   assign tag_m = tag_raw & keep;

   for (genvar s = 0; s < N_SIZES; s++) begin : g_size
      localparam int TAG_LSB = LINE_W + BASE_IDX_W + s;
      assign addr_c[s] = (ADDR_W'(tag_m) << TAG_LSB) | (ADDR_W'(idx) << LINE_W);
   end

   always_comb begin
      line_addr = '0;
      for (int s = 0; s < N_SIZES; s++) begin
         if (int'(size_eff) == s) line_addr = addr_c[s];
      end
   end
endmodule

// File: rtl/l2tag_seq.sv
module l2tag_seq
   import l2tag_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WE_CYC = 2,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_dirty,
   input  logic              hit_raw,
   input  logic              dirty_raw,
   input  logic              hit_pol,
   input  logic              dirty_pol,
   input  logic [ADDR_W-1:0] vic_in,
   output l2tag_state_e      state,
   output logic [ADDR_W-1:0] addr_q,
   output logic              dirty_q,
   output logic              res_valid,
   output logic              res_hit,
   output logic              res_dirty,
   output logic              vic_valid,
   output logic [ADDR_W-1:0] vic_addr
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         addr_q    <= '0;
         dirty_q   <= 1'b0;
         cnt       <= '0;
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_dirty <= 1'b0;
         vic_valid <= 1'b0;
         vic_addr  <= '0;
      end else begin
         res_valid <= 1'b0;
         vic_valid <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (req_valid) begin
                  case (l2tag_op_e'(req_op))
                     OP_LOOKUP: begin
                        addr_q <= req_addr;
                        state  <= S_LOOK;
                     end
                     OP_UPDATE: begin
                        addr_q  <= req_addr;
                        dirty_q <= req_dirty;
                        cnt     <= CNT_W'(WE_CYC - 1);
                        state   <= S_WRITE;
                     end
                     OP_CASTOUT: begin
                        addr_q <= req_addr;
                        state  <= S_READ;
                     end
                     default: ;
                  endcase
               end
            end
            S_LOOK: begin
               res_valid <= 1'b1;
               res_hit   <= (hit_raw == hit_pol);
               res_dirty <= (dirty_raw == dirty_pol);
               state     <= S_IDLE;
            end
            S_WRITE: begin
               if (cnt == '0) state <= S_HOLD;
               else           cnt   <= cnt - CNT_W'(1);
            end
            S_HOLD: state <= S_IDLE;
            S_READ: begin
               vic_valid <= 1'b1;
               vic_addr  <= vic_in;
               state     <= S_TURN;
            end
            S_TURN: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/l2tag_ctrl.sv
module l2tag_ctrl
   import l2tag_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_W     = 5,
   parameter int BASE_IDX_W = 13,
   parameter int N_SIZES    = 3,
   parameter int WE_CYC     = 2,
   localparam int SIZE_W    = (N_SIZES > 1) ? $clog2(N_SIZES) : 1,
   localparam int IDX_W     = BASE_IDX_W + N_SIZES - 1,
   localparam int TAG_W     = ADDR_W - LINE_W - BASE_IDX_W,
   localparam int MASK_W    = $clog2(TAG_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic [MASK_W-1:0] cfg_mask_n,
   input  logic              cfg_hit_pol,
   input  logic              cfg_dirty_pol,
   input  logic              cfg_l2_en,
   input  logic              cfg_dual_cpu,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_dirty,
   output logic              busy,
   output logic              res_valid,
   output logic              res_hit,
   output logic              res_dirty,
   output logic              vic_valid,
   output logic [ADDR_W-1:0] vic_addr,
   output logic [IDX_W-1:0]  ram_idx,
   output logic [TAG_W-1:0]  tag_dout,
   input  logic [TAG_W-1:0]  tag_din,
   output logic              tag_drive,
   output logic              tv_out,
   output logic              tv_drive,
   output logic              dirty_out,
   output logic              tag_we,
   output logic              tag_oe,
   output logic              addr_oe,
   input  logic              hit_in,
   input  logic              dirty_in
);
   localparam int CNT_W = (WE_CYC > 1) ? $clog2(WE_CYC) : 1;

   if (N_SIZES < 1 || N_SIZES > 4) begin : g_bad_sizes
      $error("l2tag_ctrl: N_SIZES must be 1..4");
   end
   if (WE_CYC < 1) begin : g_bad_we
      $error("l2tag_ctrl: WE_CYC must be at least 1");
   end
   if (LINE_W + IDX_W >= ADDR_W) begin : g_bad_split
      $error("l2tag_ctrl: index and line offset leave no tag bits");
   end

   l2tag_state_e      state;
   logic [ADDR_W-1:0] addr_q;
   logic              dirty_q;
   logic [SIZE_W-1:0] size_eff;
   logic [TAG_W-1:0]  keep;
   logic [ADDR_W-1:0] vic_line;

   l2tag_addr_map #(
      .ADDR_W(ADDR_W), .LINE_W(LINE_W), .BASE_IDX_W(BASE_IDX_W),
      .N_SIZES(N_SIZES), .SIZE_W(SIZE_W), .IDX_W(IDX_W),
      .TAG_W(TAG_W), .MASK_W(MASK_W)
   ) u_map (
      .addr(addr_q), .size(cfg_size), .mask_n(cfg_mask_n),
      .size_eff(size_eff), .idx(ram_idx), .tag(tag_dout), .keep(keep)
   );

   l2tag_victim #(
      .ADDR_W(ADDR_W), .LINE_W(LINE_W), .BASE_IDX_W(BASE_IDX_W),
      .N_SIZES(N_SIZES), .SIZE_W(SIZE_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
   ) u_vic (
      .tag_raw(tag_din), .keep(keep), .idx(ram_idx),
      .size_eff(size_eff), .line_addr(vic_line)
   );

   l2tag_seq #(
      .ADDR_W(ADDR_W), .WE_CYC(WE_CYC), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_dirty(req_dirty), .hit_raw(hit_in), .dirty_raw(dirty_in),
      .hit_pol(cfg_hit_pol), .dirty_pol(cfg_dirty_pol), .vic_in(vic_line),
      .state(state), .addr_q(addr_q), .dirty_q(dirty_q),
      .res_valid(res_valid), .res_hit(res_hit), .res_dirty(res_dirty),
      .vic_valid(vic_valid), .vic_addr(vic_addr)
   );

   logic bus_free;
   assign bus_free  = (state == S_READ) || (state == S_TURN);
   assign tag_drive = !bus_free;
   assign addr_oe   = !bus_free;
   assign tag_oe    = (state == S_READ);
   assign tag_we    = (state == S_WRITE);
   assign tv_out    = 1'b1;
   assign tv_drive  = tag_drive && cfg_l2_en && !cfg_dual_cpu;
   assign dirty_out = dirty_q;
   assign busy      = (state != S_IDLE);
endmodule

// File: rtl/l2tag_ctrl_chk.sv
module l2tag_ctrl_chk #(
   parameter int IDX_W  = 15,
   parameter int TAG_W  = 14,
   parameter int WE_CYC = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_l2_en,
   input logic             cfg_dual_cpu,
   input logic             tag_we,
   input logic             tag_oe,
   input logic             addr_oe,
   input logic             tag_drive,
   input logic             tv_drive,
   input logic [IDX_W-1:0] ram_idx,
   input logic [TAG_W-1:0] tag_dout,
   input logic             dirty_out,
   input logic             res_valid,
   input logic             vic_valid
);
   localparam int RUN_W = $clog2(WE_CYC + 2);
   logic [RUN_W-1:0] we_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      we_run <= '0;
      else if (tag_we) we_run <= we_run + RUN_W'(1);
      else             we_run <= '0;
   end

   a_r11_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(tag_we && tag_oe));
   a_r5_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      tag_oe |-> (!tag_drive && !tv_drive && !addr_oe));
   a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tag_oe) |-> (!tag_drive && !addr_oe && !tag_oe));
   a_r4_we_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_we && $past(tag_we)) |-> ($stable(tag_dout) && $stable(ram_idx) && $stable(dirty_out)));
   a_r4_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tag_we) |-> ($stable(tag_dout) && $stable(ram_idx) && $stable(dirty_out) && tag_drive));
   a_r4_we_width_max: assert property (@(posedge clk) disable iff (!rst_n)
      tag_we |-> (int'(we_run) < WE_CYC));
   a_r4_we_width_exact: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tag_we) |-> (int'(we_run) == WE_CYC));
   a_r3_res_single: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   a_r6_vic_single: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |=> !vic_valid);
   a_r8_tv_released: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_l2_en || cfg_dual_cpu) |-> !tv_drive);
endmodule

bind l2tag_ctrl l2tag_ctrl_chk #(
   .IDX_W(IDX_W), .TAG_W(TAG_W), .WE_CYC(WE_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_l2_en(cfg_l2_en), .cfg_dual_cpu(cfg_dual_cpu),
   .tag_we(tag_we), .tag_oe(tag_oe), .addr_oe(addr_oe), .tag_drive(tag_drive),
   .tv_drive(tv_drive), .ram_idx(ram_idx), .tag_dout(tag_dout),
   .dirty_out(dirty_out), .res_valid(res_valid), .vic_valid(vic_valid)
);

// File: tb/l2tag_ctrl_tb.sv
`timescale 1ns/1ps
module l2tag_ctrl_tb;
   localparam int WE = 2;
   localparam logic [13:0] JUNK = 14'h1555;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [1:0]  cfg_size = 2'd0;
   logic [3:0]  cfg_mask_n = 4'd0;
   logic        cfg_hit_pol = 1'b1, cfg_dirty_pol = 1'b1;
   logic        cfg_l2_en = 1'b1, cfg_dual_cpu = 1'b0;
   logic        req_valid = 1'b0, req_dirty = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [31:0] req_addr = '0;
   logic        busy, res_valid, res_hit, res_dirty, vic_valid;
   logic [31:0] vic_addr;
   logic [14:0] ram_idx;
   logic [13:0] tag_dout;
   logic [13:0] tag_din = ~JUNK;
   logic        tag_drive, tv_out, tv_drive, dirty_out, tag_we, tag_oe, addr_oe;
   logic        hit_in = 1'b0, dirty_in = 1'b0;

   l2tag_ctrl #(.WE_CYC(WE)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_mask_n(cfg_mask_n),
      .cfg_hit_pol(cfg_hit_pol), .cfg_dirty_pol(cfg_dirty_pol),
      .cfg_l2_en(cfg_l2_en), .cfg_dual_cpu(cfg_dual_cpu),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_dirty(req_dirty), .busy(busy), .res_valid(res_valid),
      .res_hit(res_hit), .res_dirty(res_dirty), .vic_valid(vic_valid),
      .vic_addr(vic_addr), .ram_idx(ram_idx), .tag_dout(tag_dout),
      .tag_din(tag_din), .tag_drive(tag_drive), .tv_out(tv_out),
      .tv_drive(tv_drive), .dirty_out(dirty_out), .tag_we(tag_we),
      .tag_oe(tag_oe), .addr_oe(addr_oe), .hit_in(hit_in), .dirty_in(dirty_in)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // RAM model: only what the pins wrote. Shadow: what should be stored.
   logic [13:0] rm_t [int];
   bit          rm_d [int];
   logic [13:0] sh_t [int];
   bit          sh_d [int];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int szc();
      return (cfg_size > 2'd2) ? 2 : int'(cfg_size);
   endfunction
   function automatic logic [14:0] e_idx(input logic [31:0] a);
      logic [31:0] m;
      m = (32'd1 << (13 + szc())) - 32'd1;
      return 15'((a >> 5) & m);
   endfunction
   function automatic logic [13:0] e_keep();
      logic [13:0] k;
      for (int i = 0; i < 14; i++) k[i] = (i + int'(cfg_mask_n)) < (14 - szc());
      return k;
   endfunction
   function automatic logic [13:0] e_tag(input logic [31:0] a);
      return 14'(a >> (18 + szc())) & e_keep();
   endfunction
   function automatic logic [31:0] e_vic(input logic [13:0] t, input logic [14:0] ix);
      return (32'(t & e_keep()) << (18 + szc())) | (32'(ix) << 5);
   endfunction

   task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic d);
      logic [14:0] ei;
      logic [13:0] et;
      logic [31:0] ev;
      bit eh, ed;
      ei = e_idx(a);
      et = e_tag(a);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_dirty = d;
      @(negedge clk);
      req_valid = 1'b0;
      case (op)
         2'd0: begin
            check(ram_idx == ei, "R1 index", 32'(ram_idx), 32'(ei));
            check(tag_dout == et, "R2 masked tag", 32'(tag_dout), 32'(et));
            check(addr_oe && tag_drive && !tag_we && !tag_oe, "R1 lookup drive",
                  {addr_oe, tag_drive, tag_we, tag_oe}, 32'hC);
            eh = sh_t.exists(int'(ei)) && sh_t[int'(ei)] == et;
            ed = sh_d.exists(int'(ei)) ? sh_d[int'(ei)] : 1'b0;
            hit_in = (rm_t.exists(int'(ram_idx)) && rm_t[int'(ram_idx)] == tag_dout)
                     ? cfg_hit_pol : ~cfg_hit_pol;
            dirty_in = (rm_d.exists(int'(ram_idx)) && rm_d[int'(ram_idx)])
                     ? cfg_dirty_pol : ~cfg_dirty_pol;
            @(negedge clk);
            hit_in = 1'($urandom); dirty_in = 1'($urandom);
            check(res_valid == 1'b1, "R3 strobe", 32'(res_valid), 32'd1);
            check(res_hit == eh, "R3 hit", 32'(res_hit), 32'(eh));
            check(res_dirty == ed, "R3 dirty", 32'(res_dirty), 32'(ed));
            @(negedge clk);
            check(!res_valid && !busy, "R3 single", {res_valid, busy}, 32'd0);
         end
         2'd1: begin
            for (int k = 0; k < WE; k++) begin
               check(tag_we && tag_drive && ram_idx == ei && tag_dout == et &&
                     dirty_out == d && tv_drive && tv_out, "R4 pulse",
                     {tag_we, tag_drive, tv_drive, dirty_out, 1'b0, ram_idx, tag_dout},
                     {5'b11110 | 5'(d), ei, et});
               rm_t[int'(ram_idx)] = tag_dout;
               rm_d[int'(ram_idx)] = dirty_out;
               @(negedge clk);
            end
            check(!tag_we && tag_drive && ram_idx == ei && tag_dout == et && dirty_out == d,
                  "R4 hold", {tag_we, tag_drive, ram_idx, tag_dout}, {2'b01, ei, et});
            sh_t[int'(ei)] = et;
            sh_d[int'(ei)] = d;
            @(negedge clk);
            check(!busy && !tag_we, "R4 end", {busy, tag_we}, 32'd0);
         end
         2'd2: begin
            check(tag_oe && !addr_oe && !tag_drive && !tv_drive, "R5 release",
                  {tag_oe, addr_oe, tag_drive, tv_drive}, 32'h8);
            tag_din = rm_t.exists(int'(ram_idx)) ? rm_t[int'(ram_idx)] : JUNK;
            hit_in = 1'($urandom); dirty_in = 1'($urandom);
            ev = e_vic(sh_t.exists(int'(ei)) ? sh_t[int'(ei)] : JUNK, ei);
            @(negedge clk);
            tag_din = ~JUNK;
            check(vic_valid && vic_addr == ev, "R6 victim", vic_addr, ev);
            check(!tag_oe && !addr_oe && !tag_drive, "R7 turnaround",
                  {tag_oe, addr_oe, tag_drive}, 32'd0);
            @(negedge clk);
            check(!vic_valid && !busy && tag_drive && addr_oe, "R7 resume",
                  {vic_valid, busy, tag_drive, addr_oe}, 32'h3);
         end
         default: begin
            check(!busy && !tag_we && !tag_oe, "R9 reserved op",
                  {busy, tag_we, tag_oe}, 32'd0);
         end
      endcase
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!tag_we && !tag_oe && !busy && !res_valid && !vic_valid && addr_oe && tag_drive,
            "R10 reset", {tag_we, tag_oe, busy, res_valid, vic_valid, addr_oe, tag_drive},
            32'h3);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && addr_oe && tag_drive && !tag_we, "R10 after release",
            {busy, addr_oe, tag_drive, tag_we}, 32'h6);

      // R8 valid line release
      check(tv_drive && tv_out, "R8 enabled", {tv_drive, tv_out}, 32'h3);
      cfg_l2_en = 1'b0; @(negedge clk);
      check(!tv_drive, "R8 l2 off", 32'(tv_drive), 32'd0);
      cfg_l2_en = 1'b1; cfg_dual_cpu = 1'b1; @(negedge clk);
      check(!tv_drive, "R8 dual", 32'(tv_drive), 32'd0);
      cfg_dual_cpu = 1'b0;

      // R1 / R2 directed: 512 KB with five tag bits masked
      cfg_size = 2'd1; cfg_mask_n = 4'd5;
      run_op(2'd1, 32'hFFFF_FFE0, 1'b1);
      run_op(2'd0, 32'hFFFF_FFE0, 1'b0);
      run_op(2'd0, 32'h07FF_FFE0, 1'b0);
      run_op(2'd2, 32'h0007_FFE0, 1'b0);
      cfg_size = 2'd3; cfg_mask_n = 4'd0;
      run_op(2'd0, 32'hABCD_1234, 1'b0);

      // R9: request while busy is dropped, reserved code ignored
      cfg_size = 2'd0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_addr = 32'h1234_5678;
      @(negedge clk);
      req_op = 2'd1; req_dirty = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(res_valid && !tag_we, "R9 busy drop", {res_valid, tag_we}, 32'h2);
      @(negedge clk);
      check(!busy && !tag_we, "R9 no write", {busy, tag_we}, 32'd0);
      run_op(2'd3, 32'h5555_0000, 1'b1);

      // Constrained random phases
      void'($urandom(32'h1F2E3D4C));
      for (int ph = 0; ph < 12; ph++) begin
         logic [31:0] pool [8];
         cfg_size = 2'(ph % 3);
         cfg_mask_n = 4'($urandom_range(0, 6));
         cfg_hit_pol = 1'(ph >> 1);
         cfg_dirty_pol = 1'(ph >> 2);
         rm_t.delete(); rm_d.delete(); sh_t.delete(); sh_d.delete();
         for (int p = 0; p < 8; p++) pool[p] = $urandom;
         for (int n = 0; n < 40; n++) begin
            logic [31:0] a;
            int r;
            a = pool[$urandom_range(0, 7)];
            if ($urandom_range(0, 3) == 0) a = a ^ (32'd1 << $urandom_range(18, 31));
            r = $urandom_range(0, 9);
            run_op((r < 4) ? 2'd0 : (r < 7) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3,
                   a, 1'($urandom));
         end
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule